// File: doc/BRIEF.md
# Five-Level Idle Symbol Generator

The block produces the idle stream of a four-pair line code that uses five signal levels, -2 to +2. On every accepted byte-clock cycle at 125 MHz it presents one symbol for each pair, A to D. The levels fall into two subsets. The X subset is {-1, +1}. The Y subset is {-2, 0, +2}. In each symbol the pairs alternate between the two subsets, in one of two complementary arrangements. A private 33-bit scrambler chooses which arrangement is used. The same scrambler also chooses the signs of the X levels and the Y levels of each even symbol.

Symbols come in even/odd couples. The Y value sent in a given Y position on the odd symbol is the complement, within {0, -2}, of the value sent in that position on the even symbol. As a result the -2 idle escape appears in each Y position at least once in every two symbols, which lets a receiver tell idle from data quickly.

The output is a valid/ready stream. Once reset is released, valid rises and then stays high, because an idle source always has a symbol to offer. While valid is high and ready is low, the symbol, its phase flag and the scrambler all hold, so no symbol is lost or skipped. A symbol is consumed on each clock edge where valid and ready are both high.

Top module: `idle_symbol_gen`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first edge after it, `sym_valid` is 0, every symbol output is 0 and `sym_odd` is 0.
- R2: Valid rises on the first clock edge after reset is released. That first symbol is even (`sym_odd` = 0) and is built from the scrambler's seed state `33'h0_F0E1_D2C3`.
- R3: The scrambler state s[32:0] advances once per accepted symbol and never otherwise. The update is s <= {s[31:0], s[32]^s[12]}, which is x^33+x^13+1 with the newest bit in s[0]. So the arrangement bit of accepted symbol n equals the XOR of the arrangement bits of symbols n-33 and n-13.
- R4: If s[0] is 0, pairs A,B,C,D carry X,Y,X,Y. If s[0] is 1, they carry Y,X,Y,X. The X positions (A,C or B,D) are slots 0 and 1 in pair order, and the Y positions are slots 0 and 1 in the same way.
- R5: On every symbol, X slot k (k = 0, 1) is -1 if s[3+k] is 1 and +1 if it is 0.
- R6: On an even symbol, Y slot k is -2 if s[1+k] is 1 and 0 if it is 0.
- R7: On an odd symbol, Y slot k is 0 if the preceding even symbol had -2 in that slot, and -2 otherwise. So every Y slot carries -2 at least once in each even/odd couple.
- R8: `sym_odd` starts at 0 and toggles once for each accepted symbol.
- R9: While `sym_valid` is 1 and `sym_ready` is 0, the symbol outputs and `sym_odd` hold their values, and the sequence resumes on the next acceptance with nothing skipped.
- R10: Each pair symbol is 3-bit two's complement (+1 = 001, 0 = 000, -1 = 111, -2 = 110) and stays within -2 to +2. An X level has bit 0 set and a Y level has it clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz byte clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_ready | input | 1 | Consumer accepts the current symbol |
| sym_valid | output | 1 | A symbol is offered |
| sym_a | output | 3 | Pair A level, two's complement |
| sym_b | output | 3 | Pair B level, two's complement |
| sym_c | output | 3 | Pair C level, two's complement |
| sym_d | output | 3 | Pair D level, two's complement |
| sym_odd | output | 1 | 1 on the odd symbol of a couple, 0 on the even one |

## Verification
The bench keeps its own scrambler model and compares every pair level of thousands of consecutive symbols against values computed arithmetically. This covers both arrangements, all sign choices and both phases, so errors in arrangement, X sign and Y complement each show up separately. The ready input follows a periodic single-cycle stall, a long 40-cycle stall and free-running stretches. These patterns show whether a stall freezes the scrambler or lets it slip a bit. A bit-recurrence check on the observed arrangement bits confirms the feedback taps without relying on the model. A reset in mid-stream confirms that the sequence restarts from the seed at the even phase.

// File: rtl/idle_sym_pkg.sv
package idle_sym_pkg;
  localparam int NUM_PAIRS = 4;
  localparam int NUM_SLOTS = NUM_PAIRS / 2;
  localparam int LVL_W     = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_POS1 = 3'b001;
  localparam lvl_t LVL_ZERO = 3'b000;
  localparam lvl_t LVL_NEG1 = 3'b111;
  localparam lvl_t LVL_NEG2 = 3'b110;

  // complement within the Y pair of idle values: 0 <-> -2
  function automatic lvl_t y_flip(input lvl_t v);
    return (v == LVL_NEG2) ? LVL_ZERO : LVL_NEG2;
  endfunction
endpackage

// File: rtl/idle_scrambler.sv
module idle_scrambler #(
  parameter int          SCR_LEN = 33,
  parameter int          TAP_LO  = 13,
  parameter logic [32:0] SEED    = 33'h0_F0E1_D2C3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  output logic [SCR_LEN-1:0] state
);
  localparam int LO_IDX = TAP_LO - 1;

  logic fb;
  assign fb = state[SCR_LEN-1] ^ state[LO_IDX];

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED[SCR_LEN-1:0];
    else if (step) state <= {state[SCR_LEN-2:0], fb};
  end

  AST_SCR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state != '0); // R3
  AST_SCR_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state)); // R9
endmodule

// File: rtl/idle_pair_mapper.sv
module idle_pair_mapper
  import idle_sym_pkg::*;
(
  input  logic [NUM_PAIRS:0]   rnd,
  input  logic                 odd_phase,
  input  lvl_t [NUM_SLOTS-1:0] y_prev,
  output lvl_t [NUM_PAIRS-1:0] sym,
  output lvl_t [NUM_SLOTS-1:0] y_now
);
  logic swap;
  assign swap = rnd[0];

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    lvl_t x_lvl;
    lvl_t y_lvl;
    assign x_lvl = rnd[1+NUM_SLOTS+k] ? LVL_NEG1 : LVL_POS1;
    assign y_lvl = odd_phase ? y_flip(y_prev[k])
                             : (rnd[1+k] ? LVL_NEG2 : LVL_ZERO);
    assign y_now[k]    = y_lvl;
    assign sym[2*k]    = swap ? y_lvl : x_lvl;
    assign sym[2*k+1]  = swap ? x_lvl : y_lvl;
  end
endmodule

// File: rtl/idle_symbol_gen.sv
module idle_symbol_gen
  import idle_sym_pkg::*;
#(
  parameter int          SCR_LEN = 33,
  parameter int          TAP_LO  = 13,
  parameter logic [32:0] SEED    = 33'h0_F0E1_D2C3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_ready,
  output logic       sym_valid,
  output logic [2:0] sym_a,
  output logic [2:0] sym_b,
  output logic [2:0] sym_c,
  output logic [2:0] sym_d,
  output logic       sym_odd
);
  logic                 load;
  logic                 phase;
  logic [SCR_LEN-1:0]   scr;
  lvl_t [NUM_SLOTS-1:0] y_store;
  lvl_t [NUM_SLOTS-1:0] y_next;
  lvl_t [NUM_PAIRS-1:0] sym_next;
  lvl_t [NUM_PAIRS-1:0] sym_q;

  assign load = !sym_valid || sym_ready;

  idle_scrambler #(.SCR_LEN(SCR_LEN), .TAP_LO(TAP_LO), .SEED(SEED)) u_scr (
    .clk  (clk),
    .rst  (rst),
    .step (load),
    .state(scr)
  );

  idle_pair_mapper u_map (
    .rnd      (scr[NUM_PAIRS:0]),
    .odd_phase(phase),
    .y_prev   (y_store),
    .sym      (sym_next),
    .y_now    (y_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_valid <= 1'b0;
      sym_odd   <= 1'b0;
      phase     <= 1'b0;
      sym_q     <= '0;
      y_store   <= '0;
    end else if (load) begin
      sym_valid <= 1'b1;
      sym_q     <= sym_next;
      sym_odd   <= phase;
      phase     <= ~phase;
      if (!phase) y_store <= y_next;
    end
  end

  assign sym_a = sym_q[0];
  assign sym_b = sym_q[1];
  assign sym_c = sym_q[2];
  assign sym_d = sym_q[3];

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !sym_valid && !sym_odd && sym_a == 3'b000 && sym_d == 3'b000); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    sym_valid && !sym_ready |=> sym_valid && $stable({sym_a, sym_b, sym_c, sym_d, sym_odd})); // R9
  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst)
    sym_valid && sym_ready |=> sym_odd != $past(sym_odd)); // R8
  AST_PATTERN: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> (sym_a[0] != sym_b[0]) && (sym_a[0] == sym_c[0]) && (sym_b[0] == sym_d[0])); // R4
  AST_RANGE: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> sym_a != 3'b011 && sym_a[2:1] != 2'b10 && sym_b != 3'b011 && sym_b[2:1] != 2'b10
               && sym_c != 3'b011 && sym_c[2:1] != 2'b10 && sym_d != 3'b011 && sym_d[2:1] != 2'b10); // R10
  AST_STAY_VALID: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> sym_valid); // R2
endmodule

// File: tb/idle_symbol_gen_bench.sv
module idle_symbol_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_ready = 1'b0;
  logic       sym_valid, sym_odd;
  logic [2:0] sym_a, sym_b, sym_c, sym_d;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  idle_symbol_gen u_idle_symbol_gen (
    .clk(clk), .rst(rst), .sym_ready(sym_ready), .sym_valid(sym_valid),
    .sym_a(sym_a), .sym_b(sym_b), .sym_c(sym_c), .sym_d(sym_d), .sym_odd(sym_odd)
  );

  logic [32:0] m_scr;
  bit          m_ph;
  int          m_y [2];
  bit          hist [0:4095];
  int          n_acc;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lv(input logic [2:0] v);
    return int'($signed(v));
  endfunction

  task automatic model_reset();
    m_scr = 33'h0_F0E1_D2C3;
    m_ph  = 1'b0;
    m_y[0] = 0; m_y[1] = 0;
    n_acc = 0;
  endtask

  task automatic run(input int cycles, input int base);
    bit prev_stall = 1'b0;
    logic [12:0] prev = '0;
    for (int i = 0; i < cycles; i++) begin
      int  cyc = base + i;
      bit  rdy;
      bit  pat;
      int  ox [2];
      int  oy [2];
      int  ey [2];
      if (i == 0) check(sym_valid === 1'b1 && sym_odd === 1'b0, "R2", int'(sym_valid), 1);
      if (sym_valid) begin
        pat = (sym_a[0] == 1'b0);
        if (pat) begin ox[0] = lv(sym_b); ox[1] = lv(sym_d); oy[0] = lv(sym_a); oy[1] = lv(sym_c); end
        else     begin ox[0] = lv(sym_a); ox[1] = lv(sym_c); oy[0] = lv(sym_b); oy[1] = lv(sym_d); end
        check(pat == m_scr[0] && sym_a[0] != sym_b[0] && sym_a[0] == sym_c[0] && sym_b[0] == sym_d[0],
              "R4", int'(pat), int'(m_scr[0]));
        check(sym_odd == m_ph, "R8", int'(sym_odd), int'(m_ph));
        for (int k = 0; k < 2; k++) begin
          int ex = m_scr[3+k] ? -1 : 1;
          check(ox[k] == ex, "R5", ox[k], ex);
          if (!m_ph) begin
            ey[k] = m_scr[1+k] ? -2 : 0;
            check(oy[k] == ey[k], "R6", oy[k], ey[k]);
          end else begin
            ey[k] = (m_y[k] == -2) ? 0 : -2;
            check(oy[k] == ey[k], "R7", oy[k], ey[k]);
            check(oy[k] == -2 || m_y[k] == -2, "R7", oy[k], -2);
          end
        end
        check(lv(sym_a) >= -2 && lv(sym_a) <= 2 && lv(sym_b) >= -2 && lv(sym_b) <= 2 &&
              lv(sym_c) >= -2 && lv(sym_c) <= 2 && lv(sym_d) >= -2 && lv(sym_d) <= 2,
              "R10", lv(sym_a), 0);
        if (prev_stall)
          check({sym_a, sym_b, sym_c, sym_d, sym_odd} == prev, "R9",
                int'({sym_a, sym_b, sym_c, sym_d, sym_odd}), int'(prev));
      end else begin
        check(1'b0, "R2", 0, 1);
      end
      rdy = !((cyc % 7) == 2 || (cyc >= 300 && cyc < 340) || (cyc % 11) == 5);
      sym_ready = rdy;
      prev_stall = sym_valid && !rdy;
      prev = {sym_a, sym_b, sym_c, sym_d, sym_odd};
      if (sym_valid && rdy) begin
        hist[n_acc] = pat;
        if (n_acc >= 33)
          check(hist[n_acc] == (hist[n_acc-33] ^ hist[n_acc-13]), "R3",
                int'(hist[n_acc]), int'(hist[n_acc-33] ^ hist[n_acc-13]));
        n_acc++;
        if (!m_ph) begin m_y[0] = ey[0]; m_y[1] = ey[1]; end
        m_scr = {m_scr[31:0], m_scr[32] ^ m_scr[12]};
        m_ph  = ~m_ph;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    check(sym_valid === 1'b0 && sym_odd === 1'b0 && {sym_a, sym_b, sym_c, sym_d} === 12'h000,
          "R1", int'(sym_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    run(3000, 0);
    sym_ready = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check(sym_valid === 1'b0 && sym_odd === 1'b0 && {sym_a, sym_b, sym_c, sym_d} === 12'h000,
          "R1", int'(sym_valid), 0);
    @(negedge clk);
    check(sym_valid === 1'b0, "R1", int'(sym_valid), 0);
    model_reset();
    rst = 1'b0;
    @(negedge clk);
    run(600, 5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule